// File: doc/BRIEF.md
# Keyboard Event Queue with Host Command Port

This block sits between a keyboard matrix scanner and a CPU's I/O bus. Each cycle the scanner may present one key event: a 7-bit key code, a flag that marks it as a release rather than a press, and a count of the keys held down at that moment. Accepted events go into a small first-in first-out queue. The CPU never pops the queue by reading. Instead it writes a pop command, which moves the oldest entry into a data register. It then reads that register at the data port.

The status and command port shares a single address. A read there returns the queue fill level, an error flag and a full flag. A write there carries a command byte. Bits 7:5 of that byte select the command: load the operating mode, pop the queue, clear the error flag or erase the queue. The mode selects three things: whether several keys held at once count as an error or are accepted (rollover), whether the interrupt is enabled, and whether releases are queued as well as presses. An active-low interrupt line asks for service while data or an error is pending.

Top module: `kbd_event_port`

## Requirements
- R1: After reset the status reads 00H and the data register reads 00H. The mode is cleared: multi-key error detection on, interrupt enabled, presses only. irq_n is high.
- R2: A read at address 10H returns the data register. A read at 11H returns status: bits 3:0 hold the fill count, bit 4 the error flag, bit 5 the full flag, and bits 7:6 are 0. A read at any other address returns 00H.
- R3: With mode bit 0 clear, release events are not queued. A queued press holds {0, code}.
- R4: With mode bit 0 set, press and release events are both queued. Bit 7 of the queued byte is 1 for a release and 0 for a press.
- R5: A write to 11H whose bits 7:5 are 010 (for example 40H) loads the oldest queued byte into the data register and lowers the count by one. Successive pops return bytes in arrival order.
- R6: A pop on an empty queue leaves the data register unchanged, keeps the count at 0 and does not set the error flag.
- R7: The queue holds 8 entries and shows the full flag at count 8. An event that arrives while the queue is full and no pop is issued in that cycle is dropped and sets the error flag.
- R8: When the keys-down count is above 1, the error flag is set if mode bit 3 is 0. It is left untouched if mode bit 3 is 1.
- R9: Command CEH clears the error flag. Command CFH empties the queue and leaves the data register unchanged.
- R10: irq_n is low exactly when mode bit 2 is 0 and either the count is nonzero or the error flag is set.
- R11: A write to 11H whose bits 7:5 are 000 loads mode bits 3, 2 and 0. Any other command byte, other than CEH, CFH and the pop type, has no effect.
- R12: A pop and an event arriving in the same cycle on a full queue are both carried out. The count stays at 8 and no error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_valid | input | 1 | Key event present this cycle |
| scan_code | input | 7 | Key code of the event |
| scan_release | input | 1 | 1 = release event, 0 = press event |
| scan_keys_down | input | 4 | Number of keys held down this cycle |
| host_addr | input | 8 | I/O address of the host access |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_wdata | input | 8 | Host write data (command byte) |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| irq_n | output | 1 | Active-low service request |

## Verification
A corrupted shift in the queue shows at the data port on the next pop. It appears as a byte out of arrival order, or as an earlier byte returned twice. A wrong count shows in the status read in the cycle after the push or pop that caused it. It also moves irq_n and the full flag in that same cycle. A lost or sticky error flag shows on the status read one cycle after the overflow, multi-key event or clear command. Mode bits stored in the wrong place show up as release events wrongly admitted or refused, an interrupt that never goes low, or a multi-key error that is missing or unexpected.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

  typedef struct packed {
    logic rollover;    // 1: several keys at once is not an error
    logic irq_off;     // 1: interrupt request disabled
    logic both_edges;  // 1: queue releases as well as presses
  } kbd_mode_t;

  localparam logic [2:0] CMD_TYPE_MODE = 3'b000;
  localparam logic [2:0] CMD_TYPE_POP  = 3'b010;
  localparam logic [7:0] CMD_CLR_ERR   = 8'hCE;
  localparam logic [7:0] CMD_ERASE     = 8'hCF;
  localparam logic [7:0] PORT_DATA     = 8'h10;
  localparam logic [7:0] PORT_STAT     = 8'h11;

endpackage

// File: rtl/kbd_cmd_decode.sv
module kbd_cmd_decode
  import kbd_evt_pkg::*;
(
  input  logic      cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic      do_mode,
  output logic      do_pop,
  output logic      do_clr,
  output logic      do_erase,
  output kbd_mode_t mode_new
);

  always_comb begin
    do_mode  = cmd_wr && (cmd_byte[7:5] == CMD_TYPE_MODE);
    do_pop   = cmd_wr && (cmd_byte[7:5] == CMD_TYPE_POP);
    do_clr   = cmd_wr && (cmd_byte == CMD_CLR_ERR);
    do_erase = cmd_wr && (cmd_byte == CMD_ERASE);
    mode_new.rollover   = cmd_byte[3];
    mode_new.irq_off    = cmd_byte[2];
    mode_new.both_edges = cmd_byte[0];
  end

endmodule

// File: rtl/kbd_evq_fifo.sv
module kbd_evq_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             erase,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             pop_done,
  output logic             push_drop
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [W-1:0]     mem_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             room, push_ok, upd_en;

  always_comb begin
    pop_done  = pop && (cnt_q != '0) && !erase;
    room      = (cnt_q < CNT_W'(DEPTH)) || pop_done;
    push_ok   = push && room && !erase;
    push_drop = push && !room && !erase;
    upd_en    = erase || pop_done || push_ok;
  end

  always_comb begin
    mem_n = mem_q;
    cnt_n = cnt_q;
    if (erase) begin
      cnt_n = '0;
    end else begin
      if (pop_done) begin
        for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
        cnt_n = cnt_n - CNT_W'(1);
      end
      if (push_ok) begin
        for (int i = 0; i < DEPTH; i++)
          if (CNT_W'(i) == cnt_n) mem_n[i] = push_data;
        cnt_n = cnt_n + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_n;
      mem_q <= mem_n;
    end
  end

  assign head  = mem_q[0];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/kbd_event_port.sv
module kbd_event_port
  import kbd_evt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CODE_W = 7,
  parameter int KEYS_W = 4,
  localparam int W     = CODE_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_valid,
  input  logic [CODE_W-1:0] scan_code,
  input  logic              scan_release,
  input  logic [KEYS_W-1:0] scan_keys_down,
  input  logic [7:0]        host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq_n
);

  kbd_mode_t        mode_q, mode_new;
  logic             dec_mode, dec_pop, dec_clr, dec_erase;
  logic             cmd_wr;
  logic             ev_take, multi_key;
  logic [W-1:0]     ev_byte, fifo_head;
  logic [CNT_W-1:0] cnt;
  logic             fifo_full, pop_done, push_drop;
  logic [W-1:0]     data_q;
  logic             err_q, err_n;
  logic [7:0]       status;

  assign cmd_wr = host_wr && (host_addr == PORT_STAT);

  kbd_cmd_decode u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_byte (host_wdata),
    .do_mode  (dec_mode),
    .do_pop   (dec_pop),
    .do_clr   (dec_clr),
    .do_erase (dec_erase),
    .mode_new (mode_new)
  );

  always_comb begin
    ev_take   = scan_valid && (!scan_release || mode_q.both_edges);
    ev_byte   = {scan_release && mode_q.both_edges, scan_code};
    multi_key = (scan_keys_down > KEYS_W'(1)) && !mode_q.rollover;
  end

  kbd_evq_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_take),
    .push_data (ev_byte),
    .pop       (dec_pop),
    .erase     (dec_erase),
    .head      (fifo_head),
    .count     (cnt),
    .full      (fifo_full),
    .pop_done  (pop_done),
    .push_drop (push_drop)
  );

  always_comb begin
    err_n = err_q;
    if (dec_clr) err_n = 1'b0;
    if (push_drop || multi_key) err_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (dec_mode) mode_q <= mode_new;
      err_q <= err_n;
      if (pop_done) data_q <= fifo_head;
    end
  end

  always_comb begin
    status = {2'b00, fifo_full, err_q, 4'(cnt)};
    case (host_addr)
      PORT_DATA: host_rdata = 8'(data_q);
      PORT_STAT: host_rdata = status;
      default:   host_rdata = 8'h00;
    endcase
    irq_n = !(!mode_q.irq_off && ((cnt != '0) || err_q));
  end

endmodule

// File: rtl/kbd_event_port_chk.sv
module kbd_event_port_chk #(
  parameter int DEPTH  = 8,
  parameter int KEYS_W = 4,
  parameter int W      = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt,
  input logic              err_q,
  input logic [W-1:0]      data_q,
  input logic              dec_pop,
  input logic              dec_clr,
  input logic              dec_erase,
  input logic              ev_take,
  input logic              fifo_full,
  input logic [KEYS_W-1:0] scan_keys_down,
  input logic              rollover,
  input logic              irq_off,
  input logic              irq_n
);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_drop_sets_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && fifo_full && !dec_pop && !dec_erase) |=> err_q);

  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_pop && cnt == '0 && !ev_take) |=> ($stable(data_q) && cnt == '0));

  assert_multikey_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_keys_down > KEYS_W'(1) && !rollover) |=> err_q);

  assert_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_erase |=> (cnt == '0));

  assert_clear_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_clr && !ev_take && scan_keys_down <= KEYS_W'(1)) |=> !err_q);

  assert_irq_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_off && cnt != '0) |-> !irq_n);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |-> irq_n);

endmodule

bind kbd_event_port kbd_event_port_chk #(.DEPTH(DEPTH), .KEYS_W(KEYS_W), .W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cnt            (cnt),
  .err_q          (err_q),
  .data_q         (data_q),
  .dec_pop        (dec_pop),
  .dec_clr        (dec_clr),
  .dec_erase      (dec_erase),
  .ev_take        (ev_take),
  .fifo_full      (fifo_full),
  .scan_keys_down (scan_keys_down),
  .rollover       (mode_q.rollover),
  .irq_off        (mode_q.irq_off),
  .irq_n          (irq_n)
);

// File: tb/kbd_event_port_bench.sv
module kbd_event_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_valid = 1'b0;
  logic [6:0] scan_code = '0;
  logic       scan_release = 1'b0;
  logic [3:0] scan_keys_down = '0;
  logic [7:0] host_addr = 8'h00;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  kbd_event_port u_kbd_event_port (
    .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .scan_code(scan_code),
    .scan_release(scan_release), .scan_keys_down(scan_keys_down),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_n(irq_n)
  );

  // Vector: {op[1:0], arg[7:0], exp_status[7:0], exp_data[7:0]}
  // op 0 = key press, 1 = key release, 2 = command write to 11H
  localparam logic [25:0] VEC [14] = '{
    {2'd0, 8'h05, 8'h01, 8'h00},  // R3 press queued
    {2'd0, 8'h12, 8'h02, 8'h00},  // R3
    {2'd1, 8'h12, 8'h02, 8'h00},  // R3 release ignored
    {2'd2, 8'h40, 8'h01, 8'h05},  // R5 oldest first
    {2'd2, 8'h40, 8'h00, 8'h12},  // R5
    {2'd2, 8'h40, 8'h00, 8'h12},  // R6 empty pop repeats
    {2'd2, 8'h01, 8'h00, 8'h12},  // R11 mode: both edges
    {2'd0, 8'h21, 8'h01, 8'h12},  // R4 press
    {2'd1, 8'h21, 8'h02, 8'h12},  // R4 release
    {2'd2, 8'h40, 8'h01, 8'h21},  // R4 press bit7=0
    {2'd2, 8'h40, 8'h00, 8'hA1},  // R4 release bit7=1
    {2'd2, 8'h20, 8'h00, 8'hA1},  // R11 unknown type ignored
    {2'd0, 8'h33, 8'h01, 8'hA1},  // R4
    {2'd2, 8'hCF, 8'h00, 8'hA1}   // R9 erase keeps data
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] val);
    host_addr = addr;
    #1;
    val = host_rdata;
  endtask

  task automatic cycle(input logic kv, input logic [6:0] code, input logic rel,
                       input logic [3:0] kd, input logic wr, input logic [7:0] wb);
    @(negedge clk);
    scan_valid = kv; scan_code = code; scan_release = rel; scan_keys_down = kd;
    host_wr = wr; host_wdata = wb; host_addr = 8'h11;
    @(negedge clk);
    scan_valid = 1'b0; scan_release = 1'b0; scan_keys_down = '0; host_wr = 1'b0;
  endtask

  task automatic expect_port(input string req, input logic [7:0] st, input logic [7:0] dt);
    logic [7:0] v;
    rd(8'h11, v); check({req, " status"}, v, st);
    rd(8'h10, v); check({req, " data"}, v, dt);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_port("R1", 8'h00, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd(8'h12, v); check("R2 other addr", v, 8'h00);

    for (int i = 0; i < 14; i++) begin
      logic [1:0] op;
      op = VEC[i][25:24];
      if (op == 2'd2) cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, VEC[i][23:16]);
      else cycle(1'b1, VEC[i][22:16], op[0], 4'd1, 1'b0, 8'h00);
      expect_port($sformatf("R2 vec%0d", i), VEC[i][15:8], VEC[i][7:0]);
    end

    // fill queue: R7, R10
    for (int i = 0; i < 8; i++) cycle(1'b1, 7'h40 + 7'(i), 1'b0, 4'd1, 1'b0, 8'h00);
    expect_port("R7 full", 8'h28, 8'hA1);
    check("R10 irq low", {7'd0, irq_n}, 8'h00);
    cycle(1'b1, 7'h50, 1'b0, 4'd1, 1'b0, 8'h00);
    expect_port("R7 drop", 8'h38, 8'hA1);
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'hCE);
    expect_port("R9 clear err", 8'h28, 8'hA1);
    // R12 pop and push together on full
    cycle(1'b1, 7'h51, 1'b0, 4'd1, 1'b1, 8'h40);
    expect_port("R12 pop+push", 8'h28, 8'h40);
    for (int i = 1; i < 8; i++) begin
      cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'h5F);  // R5 pop-type variant
      rd(8'h10, v); check("R5 order", v, 8'h40 + 8'(i));
    end
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'h40);
    expect_port("R5 last", 8'h00, 8'h51);
    check("R10 irq idle", {7'd0, irq_n}, 8'h01);

    // interrupt disabled: R10
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'h04);
    cycle(1'b1, 7'h10, 1'b0, 4'd1, 1'b0, 8'h00);
    expect_port("R11 mode irq off", 8'h01, 8'h51);
    check("R10 irq masked", {7'd0, irq_n}, 8'h01);
    // multi-key without rollover: R8
    cycle(1'b1, 7'h11, 1'b0, 4'd2, 1'b0, 8'h00);
    expect_port("R8 multi err", 8'h12, 8'h51);
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'hCE);
    expect_port("R9 clear", 8'h02, 8'h51);
    // rollover on
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'h0C);
    cycle(1'b1, 7'h12, 1'b0, 4'd3, 1'b0, 8'h00);
    expect_port("R8 rollover", 8'h03, 8'h51);
    cycle(1'b1, 7'h13, 1'b1, 4'd1, 1'b0, 8'h00);
    expect_port("R3 release dropped", 8'h03, 8'h51);
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'h60);
    expect_port("R11 ignored cmd", 8'h03, 8'h51);
    cycle(1'b0, '0, 1'b0, 4'd0, 1'b1, 8'hCF);
    expect_port("R9 erase", 8'h00, 8'h51);

    // reset again: R1
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_port("R1 re-reset", 8'h00, 8'h00);
    cycle(1'b1, 7'h22, 1'b1, 4'd1, 1'b0, 8'h00);
    expect_port("R1 mode cleared", 8'h00, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule